// File: doc/BRIEF.md
# Integer Execute Stage with Two-Cycle Multiply

This block is the single, unpipelined execute stage of a small in-order integer pipeline. Each cycle it may accept one decoded instruction from the register-read stage, along with both operand values, a 16-bit literal, the instruction address and the current zero flag. It performs the arithmetic, logic, literal-move and memory-address operations. It decides conditional branches and jumps, and it hands a registered result to the memory stage one cycle later.

Multiply is the one operation that takes longer. It holds the stage for two cycles. While it does, `busy` tells the upstream stages to hold their instruction, and a bubble goes downstream. For a taken branch or jump, the stage raises a redirect request with a word-aligned target, in the same cycle as the branch's own output. Each result comes with a zero-flag candidate and a mark that says whether the operation is one that updates the flag.

Top module: `exec_stage`

## Requirements
- R1: After reset, `out_valid`, `busy` and `redirect` are all low.
- R2: Operation codes on `in_op` are: 0 add, 1 subtract, 2 and, 3 or, 4 exclusive-or, 5 move-literal, 6 multiply, 7 load, 8 store, 9 branch-if-zero, 10 branch-if-not-zero, 11 jump, 12 halt. Every non-multiply instruction that is accepted appears on the outputs in the cycle after the edge that accepts it, with `out_valid` high. Its `out_op` and `out_dst` are passed through unchanged.
- R3: Add, subtract, and, or and exclusive-or produce `in_a` op `in_b`, modulo 2^32.
- R4: Move-literal produces the sign-extended literal plus zero.
- R5: Load and store produce `in_a` plus the sign-extended literal. A store also forwards `in_b` on `out_store_data`.
- R6: Multiply produces the low 32 bits of `in_a` times `in_b`.
- R7: In the cycle after a multiply is accepted, `busy` is high and `out_valid` is low. In the next cycle, the product appears with `out_valid` high and `busy` low.
- R8: An instruction presented while `busy` is high is ignored. It never appears at the outputs.
- R9: Branch-if-zero redirects when `in_zflag` is 1, and branch-if-not-zero redirects when it is 0. Both use the target `in_pc` plus the sign-extended literal.
- R10: Jump always redirects, to `in_a` plus the sign-extended literal.
- R11: A redirect target always has its two low bits cleared.
- R12: `out_zero` is high exactly when `out_result` is zero. `out_sets_z` is high only for add, subtract and multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 4 | Operation code |
| in_dst | input | 4 | Destination register index |
| in_pc | input | 32 | Instruction byte address |
| in_a | input | 32 | First operand / base / jump register |
| in_b | input | 32 | Second operand / store data |
| in_lit | input | 16 | Signed literal |
| in_zflag | input | 1 | Current zero flag |
| busy | output | 1 | Stage occupied by a multiply; hold upstream |
| out_valid | output | 1 | Result valid for the memory stage |
| out_op | output | 4 | Operation code of the result |
| out_dst | output | 4 | Destination register index |
| out_result | output | 32 | Result or address |
| out_store_data | output | 32 | Store data |
| out_zero | output | 1 | Zero-flag candidate |
| out_sets_z | output | 1 | Operation updates the zero flag |
| redirect | output | 1 | Taken branch or jump |
| redirect_target | output | 32 | Aligned fetch target |

## Verification
The hardest situation to reach is an instruction that arrives while a multiply is still in the stage. A real upstream stage would never present one, yet the stage has to drop it. The bench forces this case: during the busy cycle of every multiply it drives a valid junk instruction with distinctive operands. It then checks that the next output is the product and that the following cycle carries no valid output. Random operands, literals at both sign extremes, and zero-flag values are mixed with directed branches that use odd literals. These cover the alignment and both outcomes of each branch.

// File: rtl/exec_stage.sv
module exec_stage #(
  parameter int XLEN = 32,
  parameter int LITW = 16,
  parameter int REGW = 4,
  parameter int OPW  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  in_op,
  input  logic [REGW-1:0] in_dst,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [LITW-1:0] in_lit,
  input  logic            in_zflag,
  output logic            busy,
  output logic            out_valid,
  output logic [OPW-1:0]  out_op,
  output logic [REGW-1:0] out_dst,
  output logic [XLEN-1:0] out_result,
  output logic [XLEN-1:0] out_store_data,
  output logic            out_zero,
  output logic            out_sets_z,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_target
);
  localparam logic [OPW-1:0] OP_ADD = 0, OP_SUB = 1, OP_AND = 2, OP_OR = 3,
    OP_XOR = 4, OP_MOVC = 5, OP_MUL = 6, OP_LOAD = 7, OP_STORE = 8,
    OP_BZ = 9, OP_BNZ = 10, OP_JUMP = 11;

  logic [XLEN-1:0] lit_x, res, tgt, hold_a, hold_b, prod;
  logic [REGW-1:0] hold_dst;
  logic            taken, sets_z;

  assign lit_x = {{(XLEN-LITW){in_lit[LITW-1]}}, in_lit};
  assign prod  = hold_a * hold_b;

  always_comb begin
    res    = '0;
    taken  = 1'b0;
    tgt    = '0;
    sets_z = 1'b0;
    case (in_op)
      OP_ADD:   begin res = in_a + in_b; sets_z = 1'b1; end
      OP_SUB:   begin res = in_a - in_b; sets_z = 1'b1; end
      OP_AND:   res = in_a & in_b;
      OP_OR:    res = in_a | in_b;
      OP_XOR:   res = in_a ^ in_b;
      OP_MOVC:  res = lit_x + '0;
      OP_LOAD, OP_STORE: res = in_a + lit_x;
      OP_BZ:    begin taken = in_zflag;  tgt = in_pc + lit_x; end
      OP_BNZ:   begin taken = !in_zflag; tgt = in_pc + lit_x; end
      OP_JUMP:  begin taken = 1'b1;      tgt = in_a + lit_x; end
      default:  res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy            <= 1'b0;
      out_valid       <= 1'b0;
      out_op          <= '0;
      out_dst         <= '0;
      out_result      <= '0;
      out_store_data  <= '0;
      out_zero        <= 1'b0;
      out_sets_z      <= 1'b0;
      redirect        <= 1'b0;
      redirect_target <= '0;
      hold_a          <= '0;
      hold_b          <= '0;
      hold_dst        <= '0;
    end else if (busy) begin
      busy           <= 1'b0;
      out_valid      <= 1'b1;
      out_op         <= OP_MUL;
      out_dst        <= hold_dst;
      out_result     <= prod;
      out_store_data <= '0;
      out_zero       <= (prod == '0);
      out_sets_z     <= 1'b1;
      redirect       <= 1'b0;
    end else if (in_valid && in_op == OP_MUL) begin
      busy      <= 1'b1;
      out_valid <= 1'b0;
      redirect  <= 1'b0;
      hold_a    <= in_a;
      hold_b    <= in_b;
      hold_dst  <= in_dst;
    end else begin
      out_valid       <= in_valid;
      out_op          <= in_op;
      out_dst         <= in_dst;
      out_result      <= res;
      out_store_data  <= (in_op == OP_STORE) ? in_b : '0;
      out_zero        <= (res == '0);
      out_sets_z      <= sets_z;
      redirect        <= in_valid && taken;
      redirect_target <= {tgt[XLEN-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/exec_stage_chk.sv
module exec_stage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        out_valid,
  input logic [3:0]  out_op,
  input logic        out_zero,
  input logic [31:0] out_result,
  input logic        redirect,
  input logic [31:0] redirect_target
);
  // R7
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R7
  busy_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid);
  // R7
  mul_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (out_valid && out_op == 4'd6));
  // R9
  redirect_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> out_valid);
  // R11
  target_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (redirect_target[1:0] == 2'b00));
  // R12
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == 32'd0)));
endmodule

bind exec_stage exec_stage_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
  .out_op(out_op), .out_zero(out_zero), .out_result(out_result),
  .redirect(redirect), .redirect_target(redirect_target)
);

// File: tb/tb_exec_stage.sv
module tb_exec_stage;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_zflag = 0;
  logic [3:0] in_op = 0, in_dst = 0;
  logic [31:0] in_pc = 0, in_a = 0, in_b = 0;
  logic [15:0] in_lit = 0;
  logic busy, out_valid, out_zero, out_sets_z, redirect;
  logic [3:0] out_op, out_dst;
  logic [31:0] out_result, out_store_data, redirect_target;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  exec_stage dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [15:0] l);
    return {{16{l[15]}}, l};
  endfunction

  function automatic logic [31:0] exp_res(logic [3:0] op, logic [31:0] a, b, logic [15:0] l);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return sx(l);
      6: return a * b;
      7, 8: return a + sx(l);
      default: return 32'd0;
    endcase
  endfunction

  task automatic issue(logic [3:0] op, logic [31:0] a, b, pc, logic [15:0] l, logic z, logic [3:0] d);
    logic [31:0] r, t;
    logic tk;
    in_valid = 1; in_op = op; in_a = a; in_b = b; in_pc = pc; in_lit = l; in_zflag = z; in_dst = d;
    r = exp_res(op, a, b, l);
    tk = (op == 9 && z) || (op == 10 && !z) || op == 11;
    t = (op == 11) ? a + sx(l) : pc + sx(l);
    @(negedge clk);
    if (op == 6) begin
      chk("R7 busy", {31'd0, busy}, 1);
      chk("R7 bubble", {31'd0, out_valid}, 0);
      in_op = 0; in_a = 32'hDEAD0000; in_b = 32'h1111; in_dst = 4'hF;
      @(negedge clk);
      in_valid = 0;
      chk("R7 busy low", {31'd0, busy}, 0);
    end else in_valid = 0;
    chk("R2 valid", {31'd0, out_valid}, 1);
    chk("R2 op", {28'd0, out_op}, {28'd0, op});
    chk("R2 dst", {28'd0, out_dst}, {28'd0, d});
    if (op <= 8) chk(op == 6 ? "R6 product" : "R3 R4 R5 result", out_result, r);
    if (op == 8) chk("R5 store data", out_store_data, b);
    chk("R12 zero", {31'd0, out_zero}, {31'd0, out_result == 0});
    chk("R12 sets_z", {31'd0, out_sets_z}, {31'd0, op == 0 || op == 1 || op == 6});
    chk("R9 R10 redirect", {31'd0, redirect}, {31'd0, tk});
    if (tk) chk("R11 target", redirect_target, {t[31:2], 2'b00});
    if (op == 6) begin
      @(negedge clk);
      chk("R8 ignored", {31'd0, out_valid}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 valid", {31'd0, out_valid}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 redirect", {31'd0, redirect}, 0);
    rst_n = 1;
    issue(5, 0, 0, 4000, 16'h8000, 0, 1);
    issue(5, 0, 0, 4000, 16'h7FFF, 0, 2);
    issue(7, 100, 0, 4000, 16'hFFFC, 0, 3);
    issue(8, 40, 77, 4000, 16'd8, 0, 0);
    issue(1, 5, 5, 4000, 0, 0, 4);
    issue(6, 32'h10000, 32'h10000, 4000, 0, 0, 5);
    issue(6, 7, 6, 4000, 0, 0, 6);
    issue(9, 0, 0, 4008, 16'hFFF8, 1, 0);
    issue(9, 0, 0, 4008, 16'hFFF8, 0, 0);
    issue(10, 0, 0, 4008, 16'd13, 0, 0);
    issue(10, 0, 0, 4008, 16'd13, 1, 0);
    issue(11, 4003, 0, 4000, 16'd6, 0, 0);
    issue(12, 0, 0, 4012, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 12));
      issue(op, (i % 7 == 0) ? 32'd0 : $urandom, (i % 5 == 0) ? 32'd0 : $urandom,
            $urandom, 16'($urandom), 1'($urandom), 4'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule